// File: doc/BRIEF.md
# Wide Multiply-Accumulate Unit

This datapath multiplies one 64-bit limb taken from each of two 256-bit operands. It shifts the 128-bit product left by a whole number of limbs and adds it into a 256-bit accumulator held inside the block. The destination result and its per-half write enables are driven combinationally in the cycle of the operation, so a register file outside the block can capture them on the same clock edge that updates the accumulator.

Three writeback modes let a schedule of sixteen operations build a full 512-bit product of two 256-bit values without any carry handling:

- **Whole:** emits the whole accumulator.
- **Half:** emits the low 128 bits into one half of the destination and then drops those bits from the accumulator.
- **None:** only updates the accumulator.

A side port overwrites the accumulator directly so that software can initialise it.

Top module: `wmac_unit`

## Requirements
- R1: After reset, `acc_o` is zero and `dst_we_o` is 2'b00.
- R2: The product is the limb of `op_a_i` picked by `a_qsel_i` times the limb of `op_b_i` picked by `b_qsel_i`. Select value k picks bits [64k+63:64k].
- R3: The product is shifted left by 64 times `shift_sel_i` bits (0, 64, 128 or 192) before it is added. The sum wraps modulo 2^256.
- R4: When `clr_acc_i` is 1, the old accumulator value is treated as zero, so the result is the shifted product alone.
- R5: Whole mode (`wb_mode_i` = 2) drives the post-add sum on `dst_o` with `dst_we_o` = 2'b11. The accumulator then holds that sum.
- R6: Half mode (`wb_mode_i` = 1) writes the low 128 bits of the sum into one half of `dst_o`. `wb_half_i` = 0 selects bits [127:0] and sets `dst_we_o` = 2'b01. `wb_half_i` = 1 selects bits [255:128] and sets `dst_we_o` = 2'b10. The accumulator becomes the sum shifted right by 128.
- R7: In no-writeback mode (`wb_mode_i` = 0, and the unused code 3), `dst_we_o` stays 2'b00 and the accumulator takes the sum.
- R8: While `op_valid_i` is 0, `dst_we_o` is 2'b00 and the accumulator keeps its value, whatever the other inputs are.
- R9: When `acc_wr_i` is 1, the accumulator loads `acc_wdata_i` on the next edge. This side load has priority over a valid operation in the same cycle, and that operation is dropped with `dst_we_o` = 2'b00.
- R10: A sixteen-step schedule of limb products with offsets, two half writebacks and one whole writeback yields the exact 512-bit product of two 256-bit operands.
- R11: `dst_o` and `dst_we_o` are valid in the same cycle as the operation. `acc_o` shows the new accumulator only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Qualifies an operation this cycle |
| op_a_i | input | 256 | First wide operand |
| op_b_i | input | 256 | Second wide operand |
| a_qsel_i | input | 2 | Limb select for `op_a_i` |
| b_qsel_i | input | 2 | Limb select for `op_b_i` |
| shift_sel_i | input | 2 | Product offset in limbs |
| clr_acc_i | input | 1 | Treat prior accumulator as zero |
| wb_mode_i | input | 2 | 0 none, 1 half, 2 whole, 3 none |
| wb_half_i | input | 1 | Destination half for half mode |
| acc_wr_i | input | 1 | Side-port accumulator write |
| acc_wdata_i | input | 256 | Side-port write data |
| dst_o | output | 256 | Destination value |
| dst_we_o | output | 2 | Write enable per 128-bit half |
| acc_o | output | 256 | Current accumulator |

## Verification
The destination value and its enables are due in the same cycle as the operation, while the accumulator is due one rising edge later. The bench therefore drives each operation just after a falling edge and reads `dst_o` and `dst_we_o` one nanosecond later, before the rising edge. It reads `acc_o` one nanosecond after that edge. It also reads `acc_o` before the edge in one case, to show that it has not yet moved. The sixteen-step schedule feeds each captured half into a model register file, and the assembled 512 bits are compared with a product computed in the bench.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

    parameter int unsigned WMAC_WIDTH = 256;
    parameter int unsigned WMAC_LIMB  = 64;

    typedef enum logic [1:0] {
        WB_NONE  = 2'd0,
        WB_HALF  = 2'd1,
        WB_WHOLE = 2'd2,
        WB_RSVD  = 2'd3
    } wb_mode_e;

endpackage

// File: rtl/wmac_limb_sel.sv
module wmac_limb_sel #(
    parameter int unsigned WIDTH = 256,
    parameter int unsigned LIMB  = 64,
    localparam int unsigned NLIMB = WIDTH / LIMB,
    localparam int unsigned SELW  = $clog2(NLIMB)
) (
    input  logic [WIDTH-1:0] word_i,
    input  logic [SELW-1:0]  sel_i,
    output logic [LIMB-1:0]  limb_o
);
    logic [LIMB-1:0] limbs [NLIMB];

    for (genvar k = 0; k < NLIMB; k++) begin : g_limb
        assign limbs[k] = word_i[k*LIMB +: LIMB];
    end

    assign limb_o = limbs[sel_i];
endmodule

// File: rtl/wmac_mult.sv
module wmac_mult #(
    parameter int unsigned LIMB = 64,
    localparam int unsigned PRODW = 2 * LIMB
) (
    input  logic [LIMB-1:0]  a_i,
    input  logic [LIMB-1:0]  b_i,
    output logic [PRODW-1:0] prod_o
);
    assign prod_o = PRODW'(a_i) * PRODW'(b_i);
endmodule

// File: rtl/wmac_align.sv
module wmac_align #(
    parameter int unsigned WIDTH = 256,
    parameter int unsigned LIMB  = 64,
    localparam int unsigned NLIMB = WIDTH / LIMB,
    localparam int unsigned SELW  = $clog2(NLIMB),
    localparam int unsigned PRODW = 2 * LIMB
) (
    input  logic [PRODW-1:0] prod_i,
    input  logic [SELW-1:0]  shift_i,
    output logic [WIDTH-1:0] aligned_o
);
    logic [WIDTH-1:0] ext;
    logic [WIDTH-1:0] cand [NLIMB];

    assign ext = {{(WIDTH-PRODW){1'b0}}, prod_i};

    for (genvar k = 0; k < NLIMB; k++) begin : g_pos
        assign cand[k] = ext << (k * LIMB);
    end

    assign aligned_o = cand[shift_i];
endmodule

// File: rtl/wmac_unit.sv
module wmac_unit
    import wmac_pkg::*;
#(
    parameter int unsigned WIDTH = WMAC_WIDTH,
    parameter int unsigned LIMB  = WMAC_LIMB,
    localparam int unsigned NLIMB = WIDTH / LIMB,
    localparam int unsigned SELW  = $clog2(NLIMB),
    localparam int unsigned PRODW = 2 * LIMB,
    localparam int unsigned HALFW = WIDTH / 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             op_valid_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic [SELW-1:0]  a_qsel_i,
    input  logic [SELW-1:0]  b_qsel_i,
    input  logic [SELW-1:0]  shift_sel_i,
    input  logic             clr_acc_i,
    input  logic [1:0]       wb_mode_i,
    input  logic             wb_half_i,
    input  logic             acc_wr_i,
    input  logic [WIDTH-1:0] acc_wdata_i,
    output logic [WIDTH-1:0] dst_o,
    output logic [1:0]       dst_we_o,
    output logic [WIDTH-1:0] acc_o
);
    typedef struct packed {
        logic [WIDTH-1:0] acc;
    } mac_state_t;

    mac_state_t state_d, state_q;

    logic [LIMB-1:0]  limb_a, limb_b;
    logic [PRODW-1:0] prod;
    logic [WIDTH-1:0] aligned;
    logic [WIDTH-1:0] base;
    logic [WIDTH-1:0] sum;
    logic             op_go;
    wb_mode_e         mode;

    wmac_limb_sel #(.WIDTH(WIDTH), .LIMB(LIMB)) u_sel_a (
        .word_i (op_a_i),
        .sel_i  (a_qsel_i),
        .limb_o (limb_a)
    );

    wmac_limb_sel #(.WIDTH(WIDTH), .LIMB(LIMB)) u_sel_b (
        .word_i (op_b_i),
        .sel_i  (b_qsel_i),
        .limb_o (limb_b)
    );

    wmac_mult #(.LIMB(LIMB)) u_mult (
        .a_i    (limb_a),
        .b_i    (limb_b),
        .prod_o (prod)
    );

    wmac_align #(.WIDTH(WIDTH), .LIMB(LIMB)) u_align (
        .prod_i    (prod),
        .shift_i   (shift_sel_i),
        .aligned_o (aligned)
    );

    always_comb begin
        mode     = wb_mode_e'(wb_mode_i);
        op_go    = op_valid_i && !acc_wr_i;
        base     = clr_acc_i ? '0 : state_q.acc;
        sum      = base + aligned;
        state_d  = state_q;
        dst_o    = sum;
        dst_we_o = 2'b00;

        if (acc_wr_i) begin
            state_d.acc = acc_wdata_i;
        end else if (op_go) begin
            unique case (mode)
                WB_WHOLE: begin
                    dst_we_o    = 2'b11;
                    state_d.acc = sum;
                end
                WB_HALF: begin
                    dst_o       = {sum[HALFW-1:0], sum[HALFW-1:0]};
                    dst_we_o    = wb_half_i ? 2'b10 : 2'b01;
                    state_d.acc = sum >> HALFW;
                end
                default: begin
                    state_d.acc = sum;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_o = state_q.acc;

    AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_valid_i |-> dst_we_o == 2'b00);                                   // R8

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!op_valid_i && !acc_wr_i) |=> $stable(acc_o));                       // R8

    AST_SIDE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_wr_i |=> acc_o == $past(acc_wdata_i));                            // R9

    AST_SIDE_DROPS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_wr_i |-> dst_we_o == 2'b00);                                      // R9

    AST_HALF_ONE_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && !acc_wr_i && wb_mode_i == 2'd1) |-> $countones(dst_we_o) == 1); // R6

    AST_HALF_TOP_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && !acc_wr_i && wb_mode_i == 2'd1) |=> acc_o[WIDTH-1:HALFW] == '0); // R6

    AST_WHOLE_KEEPS_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && !acc_wr_i && wb_mode_i == 2'd2) |=> acc_o == $past(dst_o)); // R5
endmodule

// File: tb/sim_wmac_unit.sv
module sim_wmac_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [255:0] op_a = '0, op_b = '0;
    logic [1:0]   a_qsel = '0, b_qsel = '0, shift_sel = '0;
    logic         clr_acc = 1'b0;
    logic [1:0]   wb_mode = '0;
    logic         wb_half = 1'b0;
    logic         acc_wr = 1'b0;
    logic [255:0] acc_wdata = '0;
    logic [255:0] dst;
    logic [1:0]   dst_we;
    logic [255:0] acc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    wmac_unit u0 (
        .clk_i (clk), .rst_ni (rst_n), .op_valid_i (op_valid),
        .op_a_i (op_a), .op_b_i (op_b), .a_qsel_i (a_qsel), .b_qsel_i (b_qsel),
        .shift_sel_i (shift_sel), .clr_acc_i (clr_acc), .wb_mode_i (wb_mode),
        .wb_half_i (wb_half), .acc_wr_i (acc_wr), .acc_wdata_i (acc_wdata),
        .dst_o (dst), .dst_we_o (dst_we), .acc_o (acc)
    );

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] model_sum(input logic [255:0] prev, input logic [255:0] a,
            input logic [255:0] b, input int qa, input int qb, input int sh, input bit clr);
        logic [127:0] p;
        logic [511:0] wide;
        p    = 128'(a[qa*64 +: 64]) * 128'(b[qb*64 +: 64]);
        wide = 512'(p) << (64 * sh);
        return (clr ? 256'd0 : prev) + wide[255:0];
    endfunction

    // drive one operation; dst sampled before the edge, acc after it
    task automatic run_op(input logic [255:0] a, input logic [255:0] b, input int qa, input int qb,
            input int sh, input bit clr, input int mode, input bit half, input bit vld,
            output logic [255:0] d, output logic [1:0] we, output logic [255:0] acc_pre,
            output logic [255:0] acc_post);
        @(negedge clk);
        op_a = a; op_b = b; a_qsel = 2'(qa); b_qsel = 2'(qb); shift_sel = 2'(sh);
        clr_acc = clr; wb_mode = 2'(mode); wb_half = half; op_valid = vld;
        #1;
        d = dst; we = dst_we; acc_pre = acc;
        @(posedge clk);
        #1;
        acc_post = acc;
        op_valid = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic side_load(input logic [255:0] v);
        @(negedge clk);
        acc_wr = 1'b1; acc_wdata = v;
        @(posedge clk);
        #1;
        acc_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 acc after reset", 512'(acc), 512'd0);
        chk("R1 we after reset", 512'(dst_we), 512'd0);
    endtask

    task automatic t_limbs;
        logic [255:0] a, b, d, pre, post, e;
        logic [1:0] we;
        a = {64'h1111_0000_0000_0004, 64'h0000_0000_0000_0003,
             64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002};
        b = {64'h0000_0000_0000_0007, 64'hFFFF_FFFF_FFFF_FFFF,
             64'h0000_0000_0000_0005, 64'h0000_0000_0001_0000};
        for (int i = 0; i < 4; i++) begin
            run_op(a, b, i, 3 - i, 0, 1'b1, 0, 1'b0, 1'b1, d, we, pre, post);
            e = model_sum(256'd0, a, b, i, 3 - i, 0, 1'b1);
            chk("R2 limb product", 512'(post), 512'(e));
        end
    endtask

    task automatic t_shift_wrap;
        logic [255:0] a, b, d, pre, post, e;
        logic [1:0] we;
        a = {4{64'hDEAD_BEEF_0123_4567}};
        b = {4{64'h0FED_CBA9_8765_4321}};
        for (int s = 0; s < 4; s++) begin
            side_load(256'h5);
            run_op(a, b, 1, 2, s, 1'b0, 0, 1'b0, 1'b1, d, we, pre, post);
            e = model_sum(256'h5, a, b, 1, 2, s, 1'b0);
            chk("R3 shift offset", 512'(post), 512'(e));
        end
        side_load({256{1'b1}});
        run_op(a, b, 0, 0, 3, 1'b0, 0, 1'b0, 1'b1, d, we, pre, post);
        e = model_sum({256{1'b1}}, a, b, 0, 0, 3, 1'b0);
        chk("R3 wrap mod 2^256", 512'(post), 512'(e));
    endtask

    task automatic t_clear;
        logic [255:0] d, pre, post;
        logic [1:0] we;
        side_load({4{64'hAAAA_5555_AAAA_5555}});
        run_op(256'd9, 256'd7, 0, 0, 1, 1'b1, 0, 1'b0, 1'b1, d, we, pre, post);
        chk("R4 clear drops old acc", 512'(post), 512'(256'd63 << 64));
    endtask

    task automatic t_modes;
        logic [255:0] d, pre, post, e;
        logic [1:0] we;
        side_load({128'h1234, 128'h10});
        run_op(256'd3, 256'd5, 0, 0, 0, 1'b0, 2, 1'b0, 1'b1, d, we, pre, post);
        e = {128'h1234, 128'h1F};
        chk("R5 whole dst", 512'(d), 512'(e));
        chk("R5 whole we", 512'(we), 512'd3);
        chk("R5 whole acc", 512'(post), 512'(e));
        chk("R11 acc unchanged before edge", 512'(pre), 512'({128'h1234, 128'h10}));

        side_load({128'hCAFE, 128'h100});
        run_op(256'd2, 256'd2, 0, 0, 0, 1'b0, 1, 1'b0, 1'b1, d, we, pre, post);
        chk("R6 half lower data", 512'(d[127:0]), 512'(128'h104));
        chk("R6 half lower we", 512'(we), 512'd1);
        chk("R6 half acc shifted", 512'(post), 512'(256'hCAFE));

        run_op(256'd1, 256'd1, 0, 0, 2, 1'b0, 1, 1'b1, 1'b1, d, we, pre, post);
        chk("R6 half upper data", 512'(d[255:128]), 512'(128'hCAFE));
        chk("R6 half upper we", 512'(we), 512'd2);
        chk("R6 half upper acc", 512'(post), 512'(256'd1));

        side_load(256'd40);
        run_op(256'd2, 256'd1, 0, 0, 0, 1'b0, 0, 1'b1, 1'b1, d, we, pre, post);
        chk("R7 none we", 512'(we), 512'd0);
        chk("R7 none acc", 512'(post), 512'd42);
        run_op(256'd2, 256'd1, 0, 0, 0, 1'b0, 3, 1'b0, 1'b1, d, we, pre, post);
        chk("R7 code3 we", 512'(we), 512'd0);
        chk("R7 code3 acc", 512'(post), 512'd44);
    endtask

    task automatic t_idle;
        logic [255:0] d, pre, post;
        logic [1:0] we;
        side_load(256'h77);
        run_op({256{1'b1}}, {256{1'b1}}, 3, 3, 3, 1'b1, 2, 1'b1, 1'b0, d, we, pre, post);
        chk("R8 idle we", 512'(we), 512'd0);
        chk("R8 idle acc held", 512'(post), 512'(256'h77));
    endtask

    task automatic t_priority;
        logic [255:0] d, we_pad;
        logic [1:0] we;
        side_load(256'd1);
        @(negedge clk);
        op_a = 256'd9; op_b = 256'd9; a_qsel = 0; b_qsel = 0; shift_sel = 0;
        clr_acc = 0; wb_mode = 2; op_valid = 1; acc_wr = 1; acc_wdata = 256'hBEEF;
        #1;
        we = dst_we;
        @(posedge clk);
        #1;
        op_valid = 0; acc_wr = 0;
        we_pad = 256'(we);
        chk("R9 side load wins we", 512'(we_pad), 512'd0);
        chk("R9 side load wins acc", 512'(acc), 512'(256'hBEEF));
    endtask

    task automatic sched(input logic [255:0] a, input logic [255:0] b, input int qa, input int qb,
            input int sh, input bit clr, input int mode, input bit half,
            inout logic [255:0] lo, inout logic [255:0] hi, input bit tgt_hi);
        logic [255:0] d, pre, post;
        logic [1:0] we;
        run_op(a, b, qa, qb, sh, clr, mode, half, 1'b1, d, we, pre, post);
        if (tgt_hi) begin
            if (we[0]) hi[127:0] = d[127:0];
            if (we[1]) hi[255:128] = d[255:128];
        end else begin
            if (we[0]) lo[127:0] = d[127:0];
            if (we[1]) lo[255:128] = d[255:128];
        end
    endtask

    task automatic t_schedule(input logic [255:0] a, input logic [255:0] b);
        logic [255:0] lo, hi;
        logic [511:0] ref_p;
        lo = '0; hi = '0;
        side_load({4{64'h0BAD_F00D_0BAD_F00D}});
        sched(a, b, 0, 0, 0, 1, 0, 0, lo, hi, 0);
        sched(a, b, 0, 1, 1, 0, 0, 0, lo, hi, 0);
        sched(a, b, 1, 0, 1, 0, 1, 0, lo, hi, 0);
        sched(a, b, 0, 2, 0, 0, 0, 0, lo, hi, 0);
        sched(a, b, 1, 1, 0, 0, 0, 0, lo, hi, 0);
        sched(a, b, 2, 0, 0, 0, 0, 0, lo, hi, 0);
        sched(a, b, 0, 3, 1, 0, 0, 0, lo, hi, 0);
        sched(a, b, 1, 2, 1, 0, 0, 0, lo, hi, 0);
        sched(a, b, 2, 1, 1, 0, 0, 0, lo, hi, 0);
        sched(a, b, 3, 0, 1, 0, 1, 1, lo, hi, 0);
        sched(a, b, 1, 3, 0, 0, 0, 0, lo, hi, 0);
        sched(a, b, 2, 2, 0, 0, 0, 0, lo, hi, 0);
        sched(a, b, 3, 1, 0, 0, 0, 0, lo, hi, 0);
        sched(a, b, 2, 3, 1, 0, 0, 0, lo, hi, 0);
        sched(a, b, 3, 2, 1, 0, 0, 0, lo, hi, 0);
        sched(a, b, 3, 3, 2, 0, 2, 0, lo, hi, 1);
        ref_p = 512'(a) * 512'(b);
        chk("R10 512-bit product", {hi, lo}, ref_p);
    endtask

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_limbs;
        t_shift_wrap;
        t_clear;
        t_modes;
        t_idle;
        t_priority;
        t_schedule({256{1'b1}}, {256{1'b1}});
        for (int i = 0; i < 4; i++) t_schedule(rnd256(), rnd256());
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule